// File: doc/BRIEF.md
# Adaptive On-Time Gate Sequencer

This block is the digital timing core of a constant-on-time synchronous step-down controller. It receives sampled comparator flags (feedback below reference, low-side valley over-current, inductor zero crossing, soft-start reference above feedback) together with enable and a force-off from an external protection latch. From these it drives the high-side and low-side gate enables. There is no oscillator. Each high-side pulse lasts a number of clock cycles computed from the ratio of an output-voltage code to an input-voltage code, so the switching frequency stays roughly fixed as the input voltage moves.

A sequential divider runs all the time and keeps an up-to-date on-time. The gate state machine captures that value when a switching cycle begins. Between the gates it inserts a fixed dead time and enforces a minimum off time. It keeps the low side on through a valley over-current event and drops it at a zero crossing (skip mode). On startup into a pre-biased output it keeps the low side off until soft-start overtakes the feedback level, and then lets the low-side pulses widen step by step. All pins are plain level signals. The voltage codes are treated as slow static settings, so the block has no handshake and no back-pressure.

Top module: `aot_gate_sequencer`

## Requirements
- R1: While reset is low or `en` is low, `hs_on` and `ls_on` are both 0.
- R2: `hs_on` and `ls_on` are never 1 in the same cycle. At least DEAD_CYC cycles with both gates low lie between one gate falling and the other rising.
- R3: Each high-side pulse lasts exactly T cycles. T = floor((2·PERIOD_CYC·vout_code + vin_code) / (2·vin_code)), which is the ratio rounded half up and then clamped to the range 1..PERIOD_CYC (vin_code = 0 gives PERIOD_CYC). T is captured when the pulse starts.
- R4: A high-side pulse starts only after `fb_low` was sampled 1, and only when the high side has been low for at least MIN_OFF_CYC cycles. With `fb_low` held at 0, no new pulse starts.
- R5: After the dead time that follows a high-side pulse, the low side turns on. It stays on until the next cycle is requested, a zero crossing occurs, or a ramp limit is reached.
- R6: While `ocp_valley` is 1 during the low-side interval, the low side stays on and the high side stays off. This holds even when a zero crossing or a new-cycle request arrives. The limit does not latch: once the flag clears, the next high-side pulse again lasts T cycles.
- R7: When `zero_cross` is sampled 1 during the low-side interval and `ocp_valley` is 0, `ls_on` is 0 in the next cycle.
- R8: After enable, the low side is never turned on until `ss_above_fb` has been sampled 1.
- R9: Once `ss_above_fb` has been seen, low-side pulses are capped. The first pulse is capped at RAMP_INIT cycles, and each later pulse's cap is RAMP_STEP cycles larger. The cap is removed once it reaches PERIOD_CYC. With the defaults, the first three capped pulses are 4, 20 and 36 cycles.
- R10: When `en` is sampled 0 or `force_off` is sampled 1, both gates are 0 in the next cycle. The pre-bias hold and the ramp restart from their initial state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| force_off | input | 1 | Protection shutdown, both gates off |
| fb_low | input | 1 | Feedback below reference (cycle request) |
| ocp_valley | input | 1 | Low-side current above valley limit |
| zero_cross | input | 1 | Inductor current reached zero |
| ss_above_fb | input | 1 | Soft-start reference above feedback |
| vin_code | input | CODE_W | Input voltage code |
| vout_code | input | CODE_W | Output voltage code |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
Several exits from the low-side interval can be decided on the same clock edge. A valley over-current hold can coincide with a zero crossing and with a pending new-cycle request. A shutdown can arrive in the middle of a high-side pulse. The bench provokes the first case by raising `zero_cross` while `ocp_valley` is held and `fb_low` is high, and judges it by the low side staying on and the next on-time coming out at full length. For the second case it raises `force_off` in a cycle where the high side is on, then checks that both gates are off one cycle later and that the ramp restarts from its narrowest pulse. A behavioural model is compared with both gates on every clock throughout.

// File: rtl/aot_seq_pkg.sv
package aot_seq_pkg;

  typedef enum logic [2:0] {
    GS_STOP = 3'd0,
    GS_HIGH = 3'd1,
    GS_DEAD = 3'd2,
    GS_LOW  = 3'd3,
    GS_WAIT = 3'd4
  } gate_state_e;

endpackage

// File: rtl/aot_ontime_div.sv
module aot_ontime_div #(
  parameter int CODE_W     = 10,
  parameter int PERIOD_CYC = 286,
  parameter int PW         = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vin_code,
  input  logic [CODE_W-1:0] vout_code,
  output logic [PW-1:0]     ton_cyc
);

  localparam int NW = PW + CODE_W + 2;
  localparam int DW = CODE_W + 1;
  localparam int SW = $clog2(NW + 1);

  logic [SW-1:0] step_q;
  logic [NW-1:0] num_q;
  logic [DW-1:0] den_q;
  logic [DW-1:0] rem_q;
  logic [NW-1:0] quo_q;
  logic [PW-1:0] ton_q;

  logic [NW-1:0] num_w;
  logic [DW:0]   trial;
  logic [DW:0]   trial_sub;
  logic          fits;
  logic [DW-1:0] rem_nxt;
  logic [NW-1:0] quo_nxt;
  logic [PW-1:0] ton_clamped;

  // rounded ratio: (2*P*vout + vin) / (2*vin)
  assign num_w = ((NW'(PERIOD_CYC) * NW'(vout_code)) << 1) + NW'(vin_code);

  always_comb begin
    trial     = {rem_q, num_q[NW-1]};
    trial_sub = trial - {1'b0, den_q};
    fits      = (trial >= {1'b0, den_q});
    rem_nxt   = fits ? trial_sub[DW-1:0] : trial[DW-1:0];
    quo_nxt   = {quo_q[NW-2:0], fits};
    if (quo_nxt > NW'(PERIOD_CYC))
      ton_clamped = PW'(PERIOD_CYC);
    else if (quo_nxt == '0)
      ton_clamped = PW'(1);
    else
      ton_clamped = quo_nxt[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      ton_q  <= PW'(1);
    end else if (step_q == '0) begin
      num_q  <= num_w;
      den_q  <= {vin_code, 1'b0};
      rem_q  <= '0;
      quo_q  <= '0;
      step_q <= SW'(1);
    end else begin
      num_q <= num_q << 1;
      rem_q <= rem_nxt;
      quo_q <= quo_nxt;
      if (step_q == SW'(NW)) begin
        step_q <= '0;
        ton_q  <= ton_clamped;
      end else begin
        step_q <= step_q + SW'(1);
      end
    end
  end

  assign ton_cyc = ton_q;

  assert_ton_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ton_q >= PW'(1)) && (ton_q <= PW'(PERIOD_CYC)));

endmodule

// File: rtl/aot_prebias_ramp.sv
module aot_prebias_ramp #(
  parameter int PERIOD_CYC = 286,
  parameter int RAMP_INIT  = 4,
  parameter int RAMP_STEP  = 16,
  parameter int CW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          ss_above_fb,
  input  logic          ls_done,
  output logic          ls_permit,
  output logic          ramp_on,
  output logic [CW-1:0] ls_limit
);

  logic          act_q;
  logic          go_q;
  logic [CW-1:0] lim_q;
  logic [CW-1:0] lim_nxt;

  assign lim_nxt = lim_q + CW'(RAMP_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      go_q  <= 1'b0;
      lim_q <= CW'(RAMP_INIT);
    end else if (halt) begin
      act_q <= 1'b1;
      go_q  <= 1'b0;
      lim_q <= CW'(RAMP_INIT);
    end else begin
      go_q <= go_q | ss_above_fb;
      if (ls_done && act_q && go_q) begin
        lim_q <= lim_nxt;
        if (lim_nxt >= CW'(PERIOD_CYC))
          act_q <= 1'b0;
      end
    end
  end

  assign ls_permit = !act_q || go_q;
  assign ramp_on   = act_q;
  assign ls_limit  = lim_q;

  // R9: the ramp always begins at its narrowest pulse
  assert_ramp_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> (lim_q == CW'(RAMP_INIT)));

  // R10: after a halt the ramp is back in its hold state
  assert_ramp_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt) |-> (act_q && !go_q));

endmodule

// File: rtl/aot_gate_fsm.sv
module aot_gate_fsm
  import aot_seq_pkg::*;
#(
  parameter int MIN_OFF_CYC = 44,
  parameter int DEAD_CYC    = 3,
  parameter int PW          = 9,
  parameter int CW          = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          fb_low,
  input  logic          ocp_valley,
  input  logic          zero_cross,
  input  logic [PW-1:0] ton_cyc,
  input  logic          ls_permit,
  input  logic          ramp_on,
  input  logic [CW-1:0] ls_limit,
  output logic          hs_on,
  output logic          ls_on,
  output logic          ls_done
);

  localparam int OW = $clog2(MIN_OFF_CYC + 1);
  localparam logic [OW-1:0] OFF_SAT  = OW'(MIN_OFF_CYC - 1);
  localparam logic [CW-1:0] DEAD_END = CW'(DEAD_CYC - 1);

  gate_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic [OW-1:0] off_q;
  logic [PW-1:0] ton_q, ton_d;
  logic [CW:0]   cnt_p1;
  logic          trig;

  assign cnt_p1 = {1'b0, cnt_q} + (CW+1)'(1);
  assign trig   = fb_low && (off_q >= OFF_SAT);

  always_comb begin
    st_d  = st_q;
    ton_d = ton_q;
    if (halt) begin
      st_d = GS_STOP;
    end else begin
      case (st_q)
        GS_STOP: st_d = GS_WAIT;
        GS_HIGH: if (cnt_p1 == (CW+1)'(ton_q)) st_d = GS_DEAD;
        GS_DEAD: if (cnt_q == DEAD_END) st_d = ls_permit ? GS_LOW : GS_WAIT;
        GS_LOW: begin
          if (!ocp_valley &&
              (trig || zero_cross || (ramp_on && (cnt_p1 >= (CW+1)'(ls_limit)))))
            st_d = GS_WAIT;
        end
        GS_WAIT: begin
          if (trig && (cnt_q >= DEAD_END)) begin
            st_d  = GS_HIGH;
            ton_d = ton_cyc;
          end
        end
        default: st_d = GS_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GS_STOP;
      cnt_q <= '0;
      off_q <= OFF_SAT;
      ton_q <= PW'(1);
    end else begin
      st_q  <= st_d;
      ton_q <= ton_d;
      if (st_d != st_q)
        cnt_q <= '0;
      else if (cnt_q != '1)
        cnt_q <= cnt_q + CW'(1);
      if (st_q == GS_HIGH)
        off_q <= '0;
      else if (off_q < OFF_SAT)
        off_q <= off_q + OW'(1);
    end
  end

  assign hs_on   = (st_q == GS_HIGH);
  assign ls_on   = (st_q == GS_LOW);
  assign ls_done = (st_q == GS_LOW) && (st_d != GS_LOW) && !halt;

  // checker state: run of cycles with the high side low
  logic [OW:0] lo_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lo_run_q <= (OW+1)'(MIN_OFF_CYC);
    else if (hs_on)
      lo_run_q <= '0;
    else if (lo_run_q < (OW+1)'(MIN_OFF_CYC))
      lo_run_q <= lo_run_q + (OW+1)'(1);
  end

  assert_no_shoot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  assert_dead_lh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> $past(!ls_on));

  assert_dead_hl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> $past(!hs_on));

  assert_min_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> (lo_run_q >= (OW+1)'(MIN_OFF_CYC)));

  assert_valley_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_on && ocp_valley && !halt) |=> ls_on);

  assert_zero_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_on && zero_cross && !ocp_valley) |=> !ls_on);

  assert_halt_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt) |-> (!hs_on && !ls_on));

endmodule

// File: rtl/aot_gate_sequencer.sv
module aot_gate_sequencer #(
  parameter int CODE_W      = 10,
  parameter int PERIOD_CYC  = 286,
  parameter int MIN_OFF_CYC = 44,
  parameter int DEAD_CYC    = 3,
  parameter int RAMP_INIT   = 4,
  parameter int RAMP_STEP   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              force_off,
  input  logic              fb_low,
  input  logic              ocp_valley,
  input  logic              zero_cross,
  input  logic              ss_above_fb,
  input  logic [CODE_W-1:0] vin_code,
  input  logic [CODE_W-1:0] vout_code,
  output logic              hs_on,
  output logic              ls_on
);

  localparam int PW = $clog2(PERIOD_CYC + 1);
  localparam int CW = $clog2(PERIOD_CYC + RAMP_STEP + 1) + 1;

  logic          halt;
  logic [PW-1:0] ton_cyc;
  logic          ls_permit;
  logic          ramp_on;
  logic [CW-1:0] ls_limit;
  logic          ls_done;

  assign halt = !en || force_off;

  aot_ontime_div #(
    .CODE_W     (CODE_W),
    .PERIOD_CYC (PERIOD_CYC),
    .PW         (PW)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .vin_code  (vin_code),
    .vout_code (vout_code),
    .ton_cyc   (ton_cyc)
  );

  aot_prebias_ramp #(
    .PERIOD_CYC (PERIOD_CYC),
    .RAMP_INIT  (RAMP_INIT),
    .RAMP_STEP  (RAMP_STEP),
    .CW         (CW)
  ) u_ramp (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt        (halt),
    .ss_above_fb (ss_above_fb),
    .ls_done     (ls_done),
    .ls_permit   (ls_permit),
    .ramp_on     (ramp_on),
    .ls_limit    (ls_limit)
  );

  aot_gate_fsm #(
    .MIN_OFF_CYC (MIN_OFF_CYC),
    .DEAD_CYC    (DEAD_CYC),
    .PW          (PW),
    .CW          (CW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt       (halt),
    .fb_low     (fb_low),
    .ocp_valley (ocp_valley),
    .zero_cross (zero_cross),
    .ton_cyc    (ton_cyc),
    .ls_permit  (ls_permit),
    .ramp_on    (ramp_on),
    .ls_limit   (ls_limit),
    .hs_on      (hs_on),
    .ls_on      (ls_on),
    .ls_done    (ls_done)
  );

  // R8: no low-side pulse while the pre-bias hold is active
  assert_prebias_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ls_on |-> ls_permit);

  // R1: disabled means quiet
  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!en) && !en) |-> (!hs_on && !ls_on));

endmodule

// File: tb/aot_gate_sequencer_tb.sv
`timescale 1ns/1ps
module aot_gate_sequencer_tb;

  localparam int CODE_W = 10;
  localparam int P      = 286;
  localparam int MO     = 44;
  localparam int DEAD   = 3;
  localparam int RINIT  = 4;
  localparam int RSTEP  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, force_off = 1'b0, fb_low = 1'b0, ocp_valley = 1'b0;
  logic zero_cross = 1'b0, ss_above_fb = 1'b0;
  logic [CODE_W-1:0] vin_code = '0, vout_code = '0;
  logic hs_on, ls_on;

  always #2.5 clk = ~clk;

  aot_gate_sequencer #(
    .CODE_W(CODE_W), .PERIOD_CYC(P), .MIN_OFF_CYC(MO),
    .DEAD_CYC(DEAD), .RAMP_INIT(RINIT), .RAMP_STEP(RSTEP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .force_off(force_off),
    .fb_low(fb_low), .ocp_valley(ocp_valley), .zero_cross(zero_cross),
    .ss_above_fb(ss_above_fb), .vin_code(vin_code), .vout_code(vout_code),
    .hs_on(hs_on), .ls_on(ls_on)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string cur_req = "R1";
  int exp_ton = 1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int calc_ton(int vin, int vout);
    int t;
    if (vin == 0) return P;
    t = (2 * P * vout + vin) / (2 * vin);
    if (t > P) t = P;
    if (t < 1) t = 1;
    return t;
  endfunction

  // ---------------- behavioural reference ----------------
  // phases: 0 stopped, 1 high, 2 dead, 3 low, 4 waiting
  int ph, cnt, off, lim, ton, nph, noff;
  bit pbact, pbgo, trig, m_hlt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; cnt = 0; off = MO - 1; lim = RINIT; pbact = 1; pbgo = 0;
      ton = 1; m_hlt = 1;
    end else begin
      m_hlt = !en || force_off;
      trig = fb_low && (off >= MO - 1);
      noff = (ph == 1) ? 0 : ((off < MO - 1) ? off + 1 : off);
      nph = ph;
      if (m_hlt) begin
        nph = 0; lim = RINIT; pbact = 1; pbgo = 0;
      end else begin
        case (ph)
          0: nph = 4;
          1: if (cnt == ton - 1) nph = 2;
          2: if (cnt == DEAD - 1) nph = (pbact && !pbgo) ? 4 : 3;
          3: if (!ocp_valley && (trig || zero_cross || (pbact && cnt >= lim - 1))) nph = 4;
          4: if (trig && cnt >= DEAD - 1) begin
               nph = 1;
               ton = calc_ton(int'(vin_code), int'(vout_code));
             end
          default: nph = 0;
        endcase
        if (ph == 3 && nph != 3 && pbact && pbgo) begin
          lim = lim + RSTEP;
          if (lim >= P) pbact = 0;
        end
        if (ss_above_fb) pbgo = 1;
      end
      cnt = (nph != ph) ? 0 : cnt + 1;
      off = noff;
      ph = nph;
    end
  end

  // ---------------- monitors at the falling edge ----------------
  bit hs_p = 0, ls_p = 0;
  int hs_run = 0, ls_run = 0, lo_run = 1000, both_low = 1000;
  int last_gate = 0;  // 0 none, 1 high side, 2 low side
  int last_hs_w = 0;
  int ls_w[$];

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check((hs_on == (ph == 1)) && (ls_on == (ph == 3)), cur_req,
            "gate pair vs model", {hs_on, ls_on}, {(ph == 1), (ph == 3)});
      check(!(hs_on && ls_on), "R2", "both gates high", 1, 0);
      if (hs_on && !hs_p) begin
        check(lo_run >= MO, "R4", "high-side low run before start", lo_run, MO);
        if (last_gate == 2)
          check(both_low >= DEAD, "R2", "dead before high side", both_low, DEAD);
      end
      if (ls_on && !ls_p && last_gate == 1)
        check(both_low >= DEAD, "R2", "dead before low side", both_low, DEAD);
      if (!hs_on && hs_p) begin
        last_hs_w = hs_run;
        if (!m_hlt) check(hs_run == exp_ton, "R3", "high-side width", hs_run, exp_ton);
      end
      if (!ls_on && ls_p) ls_w.push_back(ls_run);
      hs_run = hs_on ? hs_run + 1 : 0;
      ls_run = ls_on ? ls_run + 1 : 0;
      lo_run = hs_on ? 0 : lo_run + 1;
      both_low = (hs_on || ls_on) ? 0 : both_low + 1;
      if (hs_on) last_gate = 1;
      if (ls_on) last_gate = 2;
      hs_p = hs_on;
      ls_p = ls_on;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      summary();
    end
  end

  initial begin
    int cnt_ls, rises;
    bit held;
    tick(3);
    check(!hs_on && !ls_on, "R1", "gates during reset", {hs_on, ls_on}, 0);
    rst_n = 1'b1;
    vin_code = 10'd600; vout_code = 10'd200; exp_ton = calc_ton(600, 200);
    ss_above_fb = 1'b1; fb_low = 1'b1;
    tick(80);
    check(!hs_on && !ls_on, "R1", "gates while disabled", {hs_on, ls_on}, 0);

    // R3 R5 R9: steady run with the ramp from its start
    cur_req = "R5";
    ls_w.delete();
    en = 1'b1;
    tick(3500);
    check(exp_ton == 95, "R3", "rounded on-time 600/200", exp_ton, 95);
    check(ls_w.size() > 3 && ls_w[0] == RINIT, "R9", "first ramp pulse",
          ls_w.size() > 0 ? ls_w[0] : -1, RINIT);
    check(ls_w.size() > 3 && ls_w[1] == RINIT + RSTEP, "R9", "second ramp pulse",
          ls_w.size() > 1 ? ls_w[1] : -1, RINIT + RSTEP);
    check(ls_w.size() > 3 && ls_w[2] == RINIT + 2 * RSTEP, "R9", "third ramp pulse",
          ls_w.size() > 2 ? ls_w[2] : -1, RINIT + 2 * RSTEP);

    // R7 zero crossing, then R4 with no request
    cur_req = "R7";
    while (!hs_on) tick(1);
    fb_low = 1'b0;
    while (!ls_on) tick(1);
    tick(5);
    zero_cross = 1'b1;
    tick(1);
    check(!ls_on, "R7", "low side after zero crossing", ls_on, 0);
    zero_cross = 1'b0;
    cur_req = "R4";
    rises = 0;
    for (int i = 0; i < 300; i++) begin
      tick(1);
      if (hs_on) rises++;
    end
    check(rises == 0, "R4", "high-side cycles without request", rises, 0);
    fb_low = 1'b1;
    tick(200);

    // R6 valley hold overlapping zero crossing and a pending request
    cur_req = "R6";
    while (!ls_on) tick(1);
    ocp_valley = 1'b1;
    held = 1;
    for (int i = 0; i < 200; i++) begin
      tick(1);
      if (i == 100) zero_cross = 1'b1;
      if (!ls_on || hs_on) held = 0;
    end
    check(held, "R6", "low side held under valley limit", held, 1);
    ocp_valley = 1'b0; zero_cross = 1'b0;
    tick(1);
    check(!ls_on, "R6", "low side released after limit", ls_on, 0);
    while (!hs_on) tick(1);
    while (hs_on) tick(1);
    check(last_hs_w == exp_ton, "R6", "on-time after limit", last_hs_w, exp_ton);

    // R10 shutdown in the middle of a high-side pulse, ramp restart
    cur_req = "R10";
    while (!hs_on) tick(1);
    force_off = 1'b1;
    tick(1);
    check(!hs_on && !ls_on, "R10", "gates after force-off", {hs_on, ls_on}, 0);
    tick(20);
    ls_w.delete();
    force_off = 1'b0;
    tick(400);
    check(ls_w.size() > 0 && ls_w[0] == RINIT, "R10", "ramp restarted",
          ls_w.size() > 0 ? ls_w[0] : -1, RINIT);
    while (!ls_on) tick(1);
    en = 1'b0;
    tick(1);
    check(!hs_on && !ls_on, "R10", "gates after disable", {hs_on, ls_on}, 0);

    // R8 pre-bias hold with clamped on-time (R3)
    cur_req = "R8";
    ss_above_fb = 1'b0;
    vin_code = 10'd300; vout_code = 10'd330; exp_ton = calc_ton(300, 330);
    tick(80);
    check(exp_ton == P, "R3", "clamp to period", exp_ton, P);
    en = 1'b1;
    cnt_ls = 0;
    for (int i = 0; i < 1500; i++) begin
      tick(1);
      if (ls_on) cnt_ls++;
    end
    check(cnt_ls == 0, "R8", "low-side cycles before soft-start", cnt_ls, 0);
    check(last_hs_w == P, "R3", "clamped width", last_hs_w, P);
    cur_req = "R9";
    ls_w.delete();
    ss_above_fb = 1'b1;
    tick(800);
    check(ls_w.size() > 0 && ls_w[0] == RINIT, "R9", "first pulse after release",
          ls_w.size() > 0 ? ls_w[0] : -1, RINIT);

    // R3 rounding half up
    cur_req = "R3";
    en = 1'b0;
    vin_code = 10'd512; vout_code = 10'd384; exp_ton = calc_ton(512, 384);
    tick(80);
    en = 1'b1;
    tick(1500);
    check(last_hs_w == 215, "R3", "half-up rounding 512/384", last_hs_w, 215);

    // R3 low clamp
    en = 1'b0;
    vin_code = 10'd1000; vout_code = 10'd1; exp_ton = calc_ton(1000, 1);
    tick(80);
    en = 1'b1;
    tick(400);
    check(last_hs_w == 1, "R3", "minimum width", last_hs_w, 1);

    en = 1'b0;
    tick(5);
    summary();
  end

endmodule